// File: doc/BRIEF.md
# Sign-Magnitude Restoring Divider with Overflow Guard

This block divides a double-width unsigned magnitude by a single-width unsigned magnitude. Both operands carry a separate sign bit. A request is taken in one cycle. The block first runs a trial subtraction of the dividend's upper half against the divisor. If the quotient could not fit in the single-width result, the block flags divide overflow and stops at once. Otherwise it performs one shift-and-subtract step per clock until every quotient bit is resolved.

Each step shifts the bit leaving the top of the partial remainder into a carry position. When that bit is 1, the partial remainder is certainly at least the divisor, so the subtraction is taken and the quotient bit is set with no comparison. When it is 0, the step keeps the subtraction only if it produced no borrow. Otherwise the partial remainder is left as it was before the subtraction. The signs are handled beside the magnitudes: the quotient sign is the exclusive OR of the two operand signs, and the remainder takes the dividend's sign.

Top module: `restoring_div`

## Requirements
- R1: After a synchronous reset, `done`, `ovf`, `quo`, `rem`, `quo_sign` and `rem_sign` are all 0.
- R2: On an accepted `start`, `quo_sign` becomes `dvd_sign XOR dvs_sign` and `rem_sign` becomes `dvd_sign`. Both values hold until the next accepted start.
- R3: If the upper W bits of the dividend are greater than or equal to the divisor, `ovf` and `done` are both 1 in the second cycle after the start cycle. In that case `rem` shows the dividend's upper half and `quo` shows its lower half.
- R4: A zero divisor always ends in overflow, whatever the dividend is.
- R5: Without overflow, `done` is high for exactly one cycle, W+1 cycles after the cycle in which `start` was sampled.
- R6: Without overflow, `quo` equals floor(dividend / divisor) and `rem` equals dividend mod divisor. Both hold after `done` until the next accepted start.
- R7: `done` is a single-cycle pulse. `ovf` rises only together with `done`, stays set while the block is idle, and clears on the next accepted start.
- R8: A `start` that arrives while a division is in progress is ignored and leaves the running result unchanged.
- R9: With W=8, dividend 448 and divisor 17 give quotient 26 and remainder 6.
- R10: Divisors with the top bit set give correct results. This includes steps in which the bit shifted out of the partial remainder is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request; taken only when idle |
| dvd_sign | input | 1 | Dividend sign |
| dvd_mag | input | 2W | Dividend magnitude |
| dvs_sign | input | 1 | Divisor sign |
| dvs_mag | input | W | Divisor magnitude |
| done | output | 1 | One-cycle completion pulse |
| ovf | output | 1 | Divide-overflow flag |
| quo | output | W | Quotient magnitude |
| rem | output | W | Remainder magnitude |
| quo_sign | output | 1 | Quotient sign |
| rem_sign | output | 1 | Remainder sign |

## Verification
The assertions assume that `start` is a plain level sampled on every edge. Operands matter only in the cycle a start is accepted, and no reset arrives mid-operation except through `rst`. The stimulus drives every input half a cycle away from the sampling edge. It deliberately raises `start` during a running division to exercise the ignore rule. Operand values cover zero divisors, an upper half equal to the divisor, an upper half one below the divisor, divisors with the top bit set, and a long run of random pairs, so both the overflow exit and the shift-carry path occur.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_RUN   = 2'd2
  } dv_state_t;
endpackage

// File: rtl/div_ovf_check.sv
// Trial subtraction of the dividend's upper half: carry out means hi >= divisor.
module div_ovf_check #(
  parameter int W = 8
) (
  input  logic [W-1:0] hi,
  input  logic [W-1:0] dvs,
  output logic         too_big
);
  logic [W:0] sum;
  always_comb begin
    sum     = {1'b0, hi} + {1'b0, ~dvs} + {{W{1'b0}}, 1'b1};
    too_big = sum[W];
  end
endmodule

// File: rtl/div_step.sv
// One shift-and-subtract step; the shifted-out bit forces the subtraction.
module div_step #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] q_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] q_out
);
  logic         e_bit;
  logic [W-1:0] a_sh;
  logic [W-1:0] q_sh;
  logic [W:0]   diff;
  logic         take;

  always_comb begin
    e_bit = a_in[W-1];
    a_sh  = {a_in[W-2:0], q_in[W-1]};
    q_sh  = {q_in[W-2:0], 1'b0};
    diff  = {1'b0, a_sh} - {1'b0, b_in};
    take  = e_bit | ~diff[W];
    a_out = take ? diff[W-1:0] : a_sh;
    q_out = {q_sh[W-1:1], take};
  end
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic too_big,
  output logic load,
  output logic step,
  output logic fin_ok,
  output logic fin_ovf,
  output logic busy
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(W);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  dv_state_t     st;
  logic [CW-1:0] cnt;

  always_comb begin
    busy    = (st != ST_IDLE);
    load    = (st == ST_IDLE) && start;
    step    = (st == ST_RUN);
    fin_ovf = (st == ST_CHECK) && too_big;
    fin_ok  = (st == ST_RUN) && (cnt == CNT_ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE:  if (start) st <= ST_CHECK;
        ST_CHECK: begin
          if (too_big) st <= ST_IDLE;
          else begin
            st  <= ST_RUN;
            cnt <= CNT_INIT;
          end
        end
        ST_RUN: begin
          cnt <= cnt - CNT_ONE;
          if (cnt == CNT_ONE) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/restoring_div.sv
module restoring_div #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           dvd_sign,
  input  logic [2*W-1:0] dvd_mag,
  input  logic           dvs_sign,
  input  logic [W-1:0]   dvs_mag,
  output logic           done,
  output logic           ovf,
  output logic [W-1:0]   quo,
  output logic [W-1:0]   rem,
  output logic           quo_sign,
  output logic           rem_sign
);
  logic [W-1:0] a_reg, q_reg, b_reg;
  logic [W-1:0] a_nx, q_nx;
  logic         qs_reg, rs_reg, ovf_reg, done_reg;
  logic         too_big, load, step, fin_ok, fin_ovf, busy;

  div_ovf_check #(.W(W)) u_chk (
    .hi(a_reg), .dvs(b_reg), .too_big(too_big)
  );

  div_step #(.W(W)) u_step (
    .a_in(a_reg), .q_in(q_reg), .b_in(b_reg), .a_out(a_nx), .q_out(q_nx)
  );

  div_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .too_big(too_big),
    .load(load), .step(step), .fin_ok(fin_ok), .fin_ovf(fin_ovf), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_reg    <= '0;
      q_reg    <= '0;
      b_reg    <= '0;
      qs_reg   <= 1'b0;
      rs_reg   <= 1'b0;
      ovf_reg  <= 1'b0;
      done_reg <= 1'b0;
    end else begin
      done_reg <= fin_ok | fin_ovf;
      if (load) begin
        a_reg   <= dvd_mag[2*W-1:W];
        q_reg   <= dvd_mag[W-1:0];
        b_reg   <= dvs_mag;
        qs_reg  <= dvd_sign ^ dvs_sign;
        rs_reg  <= dvd_sign;
        ovf_reg <= 1'b0;
      end else if (fin_ovf) begin
        ovf_reg <= 1'b1;
      end else if (step) begin
        a_reg <= a_nx;
        q_reg <= q_nx;
      end
    end
  end

  assign done     = done_reg;
  assign ovf      = ovf_reg;
  assign quo      = q_reg;
  assign rem      = a_reg;
  assign quo_sign = qs_reg;
  assign rem_sign = rs_reg;
endmodule

// File: rtl/restoring_div_chk.sv
module restoring_div_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic         ovf,
  input logic         quo_sign,
  input logic [W-1:0] rem,
  input logic [W-1:0] b_reg
);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_ovf_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> done);

  p_zero_dvs_r4: assert property (@(posedge clk) disable iff (rst)
    (done && b_reg == '0) |-> ovf);

  p_ignore_start_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(b_reg));

  p_sign_hold_r2: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(quo_sign));

  p_rem_small_r6: assert property (@(posedge clk) disable iff (rst)
    (done && !ovf) |-> (rem < b_reg));
endmodule

bind restoring_div restoring_div_chk #(.W(W)) u_chk_bind (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .ovf(ovf), .quo_sign(quo_sign), .rem(rem), .b_reg(b_reg)
);

// File: tb/sim_restoring_div.sv
module sim_restoring_div;
  localparam int W = 8;
  localparam int LIMIT = 150000;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic           dvd_sign = 1'b0;
  logic [2*W-1:0] dvd_mag = '0;
  logic           dvs_sign = 1'b0;
  logic [W-1:0]   dvs_mag = '0;
  logic           done, ovf, quo_sign, rem_sign;
  logic [W-1:0]   quo, rem;

  always #4 clk = ~clk;

  restoring_div #(.W(W)) u0 (
    .clk(clk), .rst(rst), .start(start), .dvd_sign(dvd_sign), .dvd_mag(dvd_mag),
    .dvs_sign(dvs_sign), .dvs_mag(dvs_mag), .done(done), .ovf(ovf),
    .quo(quo), .rem(rem), .quo_sign(quo_sign), .rem_sign(rem_sign)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;

  // behavioural reference model
  bit m_busy = 0;
  int m_cnt = 0;
  bit m_done = 0;
  bit m_ovf = 0;
  bit m_pend_ovf = 0;
  int m_q = 0, m_r = 0, m_pq = 0, m_pr = 0;
  bit m_qs = 0, m_rs = 0;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_busy = 0; m_cnt = 0; m_done = 0; m_ovf = 0;
      m_q = 0; m_r = 0; m_qs = 0; m_rs = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_ovf = m_pend_ovf;
          m_q = m_pq; m_r = m_pr;
        end
      end else if (start) begin
        int hi, lo, dd;
        dd = int'(dvd_mag);
        hi = dd >> W;
        lo = dd % (1 << W);
        m_busy = 1; m_ovf = 0;
        m_qs = dvd_sign ^ dvs_sign; m_rs = dvd_sign;
        if (hi >= int'(dvs_mag)) begin
          m_pend_ovf = 1; m_cnt = 1; m_pq = lo; m_pr = hi;
        end else begin
          m_pend_ovf = 0; m_cnt = W + 1;
          m_pq = dd / int'(dvs_mag); m_pr = dd % int'(dvs_mag);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(done == m_done, "R5 done timing", int'(done), int'(m_done));
      chk(ovf == m_ovf, "R3 ovf flag", int'(ovf), int'(m_ovf));
      chk(quo_sign == m_qs, "R2 quo_sign", int'(quo_sign), int'(m_qs));
      chk(rem_sign == m_rs, "R2 rem_sign", int'(rem_sign), int'(m_rs));
      if (!m_busy) begin
        chk(int'(quo) == m_q, "R6 quotient", int'(quo), m_q);
        chk(int'(rem) == m_r, "R6 remainder", int'(rem), m_r);
      end
    end
  end

  task automatic issue(input bit ds, input int dm, input bit vs, input int vm);
    @(negedge clk);
    dvd_sign = ds; dvd_mag = (2*W)'(dm); dvs_sign = vs; dvs_mag = W'(vm);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_op();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(done == 0 && ovf == 0, "R1 reset flags", int'({done, ovf}), 0);
    chk(quo == 0 && rem == 0, "R1 reset data", int'({quo, rem}), 0);
    chk(quo_sign == 0 && rem_sign == 0, "R1 reset signs", int'({quo_sign, rem_sign}), 0);
    rst = 1'b0;
    @(negedge clk);

    // R9: reference pair
    issue(1'b0, 448, 1'b0, 17);
    finish_op();
    chk(quo == 26, "R9 quotient", int'(quo), 26);
    chk(rem == 6, "R9 remainder", int'(rem), 6);

    // R2: sign combinations
    issue(1'b1, 1000, 1'b0, 33); finish_op();
    chk(quo_sign == 1 && rem_sign == 1, "R2 neg/pos", int'({quo_sign, rem_sign}), 3);
    issue(1'b1, 1000, 1'b1, 33); finish_op();
    chk(quo_sign == 0 && rem_sign == 1, "R2 neg/neg", int'({quo_sign, rem_sign}), 1);
    issue(1'b0, 1000, 1'b1, 33); finish_op();
    chk(quo_sign == 1 && rem_sign == 0, "R2 pos/neg", int'({quo_sign, rem_sign}), 2);

    // R4: zero divisor
    issue(1'b0, 5, 1'b0, 0); finish_op();
    chk(ovf == 1, "R4 zero divisor", int'(ovf), 1);
    // R7: ovf held while idle
    repeat (5) @(negedge clk);
    chk(ovf == 1, "R7 ovf held", int'(ovf), 1);

    // R3: upper half equals divisor
    issue(1'b0, (40 << W) + 7, 1'b0, 40); finish_op();
    chk(ovf == 1 && rem == 40 && quo == 7, "R3 boundary ovf", int'({ovf, rem, quo}),
        int'({1'b1, 8'd40, 8'd7}));
    // upper half one below divisor: largest quotients
    issue(1'b0, (39 << W) + 255, 1'b0, 40); finish_op();
    chk(ovf == 0, "R7 ovf cleared", int'(ovf), 0);

    // R10: divisor with top bit set
    issue(1'b0, (199 << W) + 255, 1'b0, 200); finish_op();
    chk(int'(quo) == ((199 * 256 + 255) / 200), "R10 quotient", int'(quo), (199 * 256 + 255) / 200);
    chk(int'(rem) == ((199 * 256 + 255) % 200), "R10 remainder", int'(rem), (199 * 256 + 255) % 200);
    issue(1'b0, 65279, 1'b0, 255); finish_op();
    chk(quo == 255 && rem == 254, "R10 max operands", int'({quo, rem}), int'({8'd255, 8'd254}));

    // R8: start during a running division is ignored
    issue(1'b0, 3000, 1'b0, 50);
    repeat (3) @(negedge clk);
    dvd_mag = 16'd7; dvs_mag = 8'd0; dvd_sign = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_op();
    chk(quo == 60 && rem == 0 && ovf == 0, "R8 ignored start", int'({ovf, quo, rem}),
        int'({1'b0, 8'd60, 8'd0}));

    // R5/R6: random pairs, including back-to-back starts
    for (int i = 0; i < 300; i++) begin
      int vm, dm;
      vm = int'($urandom % 256);
      dm = int'($urandom % 65536);
      if (i % 3 != 0 && vm != 0) dm = ((dm >> W) % vm) * 256 + (dm % 256);
      issue(1'(i % 2), dm, 1'((i / 2) % 2), vm);
      finish_op();
    end

    summary();
  end

  initial begin
    while (cyc < LIMIT) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
      summary();
    end
  end
endmodule